// File: doc/BRIEF.md
# Level and Edge Pattern Trigger

The block watches a sampled input bus of 32 channels. A sample counts only when `smp_valid` is high. Each channel can be left free or required to be high or low. One channel can also be required to show a rising, falling or either-direction transition compared with the previous counted sample. A sample that meets both the level condition and the edge condition is a match.

The block counts matches. When the number of matches reaches the programmed limit, it raises a one-cycle trigger pulse and sets a sticky flag. The flag stays set, and no further pulses are issued, until `arm` restarts the search.

The level masks and the edge selector are static configuration ports. The 16-bit match limit is loaded one byte at a time through a small write port.

Top module: `lvl_edge_trigger`

## Requirements
- R1: After reset, `trig_pulse` and `triggered` are 0, no match history is held, and the match limit register holds 1.
- R2: Channel c is controlled by the two-bit code at bits (c%4)*2+1:(c%4)*2 of mask byte c/4, where mask byte k is `lvl_mask[8k+7:8k]`. Code 01 requires the channel to be high and code 10 requires it to be low. Codes 00 and 11 leave the channel free.
- R3: `edge_cfg[4:0]` selects the edge channel. `edge_cfg[7:6]` selects the edge kind: 01 rising (previous 0, current 1), 10 falling (previous 1, current 0), 11 either transition. The comparison is made against the previous counted sample, and `edge_cfg[5]` has no effect.
- R4: When `edge_cfg[7:6]` is 00 the edge condition is always true, and only the level condition decides a match.
- R5: The first counted sample after reset or after `arm` never satisfies an enabled edge condition.
- R6: A cycle with `smp_valid` low neither counts a match nor becomes the previous sample for edge detection.
- R7: `cnt_wr_lo` loads `cnt_wdata` into bits 7:0 of the match limit and `cnt_wr_hi` loads it into bits 15:8. A write takes effect for samples in later cycles. A limit of 0 behaves as a limit of 1.
- R8: Matches accumulate, and non-matching samples in between do not reset the count. On the counted sample that brings the count to the limit, `trig_pulse` is high for exactly one cycle in the cycle after that sample.
- R9: `triggered` rises together with `trig_pulse` and stays high, with no further pulses, until `arm`. A cycle with `arm` high clears the flag, the match count and the edge history, and any sample presented in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Restart the search and clear the sticky flag |
| smp_valid | input | 1 | Marks `smp_data` as a sample to evaluate |
| smp_data | input | 32 | Sampled channel values |
| lvl_mask | input | 64 | Eight mask bytes, two bits per channel |
| edge_cfg | input | 8 | Edge kind in [7:6], edge channel in [4:0] |
| cnt_wr_lo | input | 1 | Load low byte of the match limit |
| cnt_wr_hi | input | 1 | Load high byte of the match limit |
| cnt_wdata | input | 8 | Byte written to the match limit |
| trig_pulse | output | 1 | One-cycle pulse when the limit is reached |
| triggered | output | 1 | Sticky trigger flag |

## Verification
The bench targets the places where the edge history can go stale:
- An edge straddling an `arm` must not fire. A design that kept the history across `arm` would fire on the first sample.
- Idle cycles must be skipped. A design that let them overwrite the history would invent or lose transitions.

It writes a limit above 255 and a limit of 0. A design that dropped the high byte would fire far too early. A design that did not treat zero as one would count through 65536 matches. It interleaves non-matching and invalid samples between matches, which exposes a counter that clears on a miss or counts idle cycles. It keeps presenting matches after the trigger, which exposes a flag that is not sticky or a pulse that repeats.

// File: rtl/ltrig_pkg.sv
package ltrig_pkg;
    localparam int LIMIT_W = 16;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_kind_e;

    localparam logic [1:0] PAIR_NEED_HIGH = 2'b01;
    localparam logic [1:0] PAIR_NEED_LOW  = 2'b10;
endpackage

// File: rtl/ltrig_level_match.sv
module ltrig_level_match #(
    parameter int CH = 32
) (
    input  logic [CH-1:0]   smp,
    input  logic [2*CH-1:0] masks,
    output logic            ok
);
    import ltrig_pkg::*;

    logic [CH-1:0] chan_ok;

    // Channel c sits in byte c/4 at pair (c%4)*2, which is flat bit 2*c.
    for (genvar i = 0; i < CH; i++) begin : g_chan
        logic [1:0] code;
        assign code       = masks[2*i +: 2];
        assign chan_ok[i] = (code == PAIR_NEED_HIGH) ? smp[i]  :
                            (code == PAIR_NEED_LOW)  ? !smp[i] : 1'b1;
    end

    assign ok = &chan_ok;
endmodule

// File: rtl/ltrig_edge_check.sv
module ltrig_edge_check #(
    parameter int CH = 32
) (
    input  logic [CH-1:0] smp,
    input  logic [CH-1:0] prev,
    input  logic          prev_ok,
    input  logic [7:0]    edge_cfg,
    output logic          ok
);
    import ltrig_pkg::*;

    localparam int SEL_W = $clog2(CH);

    edge_kind_e       kind;
    logic [SEL_W-1:0] sel;
    logic             cur_b, old_b;
    logic             spare_unused;

    assign kind         = edge_kind_e'(edge_cfg[7:6]);
    assign sel          = edge_cfg[SEL_W-1:0];
    assign spare_unused = ^edge_cfg[5:SEL_W];
    assign cur_b        = smp[sel];
    assign old_b        = prev[sel];

    always_comb begin
        unique case (kind)
            EDGE_OFF:  ok = 1'b1;
            EDGE_RISE: ok = prev_ok && !old_b && cur_b;
            EDGE_FALL: ok = prev_ok && old_b && !cur_b;
            default:   ok = prev_ok && (old_b != cur_b);
        endcase
    end
endmodule

// File: rtl/ltrig_occ_count.sv
module ltrig_occ_count #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] hits,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] hits_inc,
    output logic             reached
);
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] eff_limit;

    assign sum       = {1'b0, hits} + {{CNT_W{1'b0}}, 1'b1};
    assign eff_limit = (limit == '0) ? CNT_W'(1) : limit;
    assign reached   = (sum >= {1'b0, eff_limit});
    assign hits_inc  = sum[CNT_W-1:0];
endmodule

// File: rtl/lvl_edge_trigger.sv
module lvl_edge_trigger #(
    parameter int CH = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            smp_valid,
    input  logic [CH-1:0]   smp_data,
    input  logic [2*CH-1:0] lvl_mask,
    input  logic [7:0]      edge_cfg,
    input  logic            cnt_wr_lo,
    input  logic            cnt_wr_hi,
    input  logic [7:0]      cnt_wdata,
    output logic            trig_pulse,
    output logic            triggered
);
    import ltrig_pkg::*;

    localparam int CNT_W = LIMIT_W;

    typedef struct packed {
        logic [CH-1:0]    prev;
        logic             prev_ok;
        logic [CNT_W-1:0] hits;
        logic [CNT_W-1:0] limit;
        logic             fired;
        logic             pulse;
    } state_t;

    state_t s_d, s_q;

    logic             lvl_ok, edg_ok, reached;
    logic [CNT_W-1:0] hits_inc;

    ltrig_level_match #(.CH(CH)) u_lvl (
        .smp   (smp_data),
        .masks (lvl_mask),
        .ok    (lvl_ok)
    );

    ltrig_edge_check #(.CH(CH)) u_edge (
        .smp      (smp_data),
        .prev     (s_q.prev),
        .prev_ok  (s_q.prev_ok),
        .edge_cfg (edge_cfg),
        .ok       (edg_ok)
    );

    ltrig_occ_count #(.CNT_W(CNT_W)) u_cnt (
        .hits     (s_q.hits),
        .limit    (s_q.limit),
        .hits_inc (hits_inc),
        .reached  (reached)
    );

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (arm) begin
            s_d.fired   = 1'b0;
            s_d.hits    = '0;
            s_d.prev_ok = 1'b0;
        end else if (smp_valid) begin
            if (!s_q.fired && lvl_ok && edg_ok) begin
                if (reached) begin
                    s_d.pulse = 1'b1;
                    s_d.fired = 1'b1;
                    s_d.hits  = '0;
                end else begin
                    s_d.hits  = hits_inc;
                end
            end
            s_d.prev    = smp_data;
            s_d.prev_ok = 1'b1;
        end
        if (cnt_wr_lo) s_d.limit[7:0]       = cnt_wdata;
        if (cnt_wr_hi) s_d.limit[CNT_W-1:8] = cnt_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.limit <= CNT_W'(1);
        end else begin
            s_q <= s_d;
        end
    end

    assign trig_pulse = s_q.pulse;
    assign triggered  = s_q.fired;
endmodule

// File: rtl/ltrig_checker.sv
module ltrig_checker (
    input logic clk,
    input logic rst_n,
    input logic arm,
    input logic smp_valid,
    input logic trig_pulse,
    input logic triggered
);
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    p_pulse_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $rose(triggered));

    p_flag_needs_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> trig_pulse);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered);

    p_arm_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!triggered && !trig_pulse));

    p_idle_no_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !trig_pulse);
endmodule

bind lvl_edge_trigger ltrig_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .smp_valid  (smp_valid),
    .trig_pulse (trig_pulse),
    .triggered  (triggered)
);

// File: tb/lvl_edge_trigger_tb.sv
`timescale 1ns/1ps
module lvl_edge_trigger_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic [63:0] lvl_mask = '0;
    logic [7:0]  edge_cfg = '0;
    logic        cnt_wr_lo = 1'b0;
    logic        cnt_wr_hi = 1'b0;
    logic [7:0]  cnt_wdata = '0;
    logic        trig_pulse, triggered;

    int    n_checks = 0;
    int    n_errs = 0;
    string cur_req = "R1";
    bit    finished = 0;

    always #2.5 clk = ~clk;

    lvl_edge_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
        .smp_data(smp_data), .lvl_mask(lvl_mask), .edge_cfg(edge_cfg),
        .cnt_wr_lo(cnt_wr_lo), .cnt_wr_hi(cnt_wr_hi), .cnt_wdata(cnt_wdata),
        .trig_pulse(trig_pulse), .triggered(triggered)
    );

    // ---------------- behavioural reference ----------------
    bit          m_pulse, m_trig, m_pv;
    int          m_hits;
    int          m_limit;
    logic [31:0] m_prev;

    function automatic bit ref_level(input logic [63:0] lm, input logic [31:0] d);
        for (int c = 0; c < 32; c++) begin
            logic [7:0] byt;
            logic [1:0] code;
            byt  = lm[(c/4)*8 +: 8];
            code = byt[(c%4)*2 +: 2];
            if (code == 2'b01 && d[c] !== 1'b1) return 0;
            if (code == 2'b10 && d[c] !== 1'b0) return 0;
        end
        return 1;
    endfunction

    function automatic bit ref_edge(input logic [7:0] e, input logic [31:0] d,
                                    input logic [31:0] p, input bit pv);
        int ch;
        ch = int'(e[4:0]);
        if (e[7:6] == 2'b00) return 1;
        if (!pv) return 0;
        if (e[7:6] == 2'b01) return (p[ch] == 1'b0 && d[ch] == 1'b1);
        if (e[7:6] == 2'b10) return (p[ch] == 1'b1 && d[ch] == 1'b0);
        return (p[ch] != d[ch]);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pulse = 0; m_trig = 0; m_pv = 0; m_hits = 0; m_limit = 1; m_prev = '0;
        end else begin
            int lim;
            m_pulse = 0;
            lim = (m_limit == 0) ? 1 : m_limit;
            if (arm) begin
                m_trig = 0; m_hits = 0; m_pv = 0;
            end else if (smp_valid) begin
                if (!m_trig && ref_level(lvl_mask, smp_data) &&
                    ref_edge(edge_cfg, smp_data, m_prev, m_pv)) begin
                    m_hits++;
                    if (m_hits >= lim) begin
                        m_pulse = 1; m_trig = 1; m_hits = 0;
                    end
                end
                m_prev = smp_data; m_pv = 1;
            end
            if (cnt_wr_lo) m_limit = (m_limit & 32'hFF00) | int'(cnt_wdata);
            if (cnt_wr_hi) m_limit = (m_limit & 32'h00FF) | (int'(cnt_wdata) << 8);
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check({cur_req, " pulse"}, trig_pulse, m_pulse);
            check({cur_req, " flag"}, triggered, m_trig);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input bit v, input logic [31:0] d, input bit a,
                        input bit wl, input bit wh, input logic [7:0] wd);
        @(negedge clk);
        smp_valid = v; smp_data = d; arm = a;
        cnt_wr_lo = wl; cnt_wr_hi = wh; cnt_wdata = wd;
        @(posedge clk); #1;
        smp_valid = 0; arm = 0; cnt_wr_lo = 0; cnt_wr_hi = 0;
    endtask

    task automatic samp(input logic [31:0] d);
        tick(1, d, 0, 0, 0, 8'h00);
    endtask

    task automatic do_arm();
        tick(0, 32'h0, 1, 0, 0, 8'h00);
    endtask

    task automatic set_limit(input int val);
        tick(0, 32'h0, 0, 1, 0, val[7:0]);
        tick(0, 32'h0, 0, 0, 1, val[15:8]);
    endtask

    task automatic set_pair(input int ch, input logic [1:0] code);
        lvl_mask[(ch/4)*8 + (ch%4)*2 +: 2] = code;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        cur_req = "R1";
        check("R1 reset pulse", trig_pulse, 1'b0);
        check("R1 reset flag", triggered, 1'b0);
        @(negedge clk); rst_n = 1;

        // R2 level codes; default limit of 1 (R1/R7)
        cur_req = "R2";
        set_pair(5, 2'b01); set_pair(30, 2'b10); set_pair(0, 2'b11); set_pair(1, 2'b00);
        edge_cfg = 8'h00;
        samp(32'h4000_0020); check("R2 ch30 high blocks", trig_pulse, 1'b0);
        samp(32'h0000_0000); check("R2 ch5 low blocks", trig_pulse, 1'b0);
        samp(32'h0000_0021); check("R2 match fires at default limit R1", trig_pulse, 1'b1);
        check("R2 flag set", triggered, 1'b1);

        // R9 sticky and arm
        cur_req = "R9";
        samp(32'h0000_0022); check("R9 no second pulse", trig_pulse, 1'b0);
        check("R9 flag sticky", triggered, 1'b1);
        tick(1, 32'h0000_0020, 1, 0, 0, 8'h00);
        check("R9 arm clears flag", triggered, 1'b0);
        check("R9 sample on arm ignored", trig_pulse, 1'b0);

        // R6 invalid cycles ignored
        cur_req = "R6";
        tick(0, 32'h0000_0020, 0, 0, 0, 8'h00);
        check("R6 idle cycle no pulse", trig_pulse, 1'b0);
        check("R6 idle cycle no flag", triggered, 1'b0);
        samp(32'h0000_0020); check("R6 next valid fires", trig_pulse, 1'b1);
        do_arm();

        // R7/R8 limit 3, accumulation across misses and idle cycles
        cur_req = "R8";
        set_limit(3);
        samp(32'h0000_0020); check("R8 match 1", trig_pulse, 1'b0);
        samp(32'h0000_0000); check("R8 miss", trig_pulse, 1'b0);
        tick(0, 32'h0000_0020, 0, 0, 0, 8'h00);
        samp(32'h0000_0020); check("R8 match 2", trig_pulse, 1'b0);
        samp(32'h0000_0020); check("R8 match 3 fires", trig_pulse, 1'b1);
        @(posedge clk); #1;
        check("R8 pulse lasts one cycle", trig_pulse, 1'b0);
        do_arm();

        // R7 high byte: limit 0x0102 = 258
        cur_req = "R7";
        set_limit(16'h0102);
        for (int k = 1; k < 258; k++) begin
            samp(32'h0000_0020);
            if (k == 255) check("R7 no fire at 255", trig_pulse, 1'b0);
        end
        check("R7 no fire at 257", trig_pulse, 1'b0);
        samp(32'h0000_0020); check("R7 fires at 258", trig_pulse, 1'b1);
        do_arm();
        set_limit(0);
        samp(32'h0000_0020); check("R7 zero limit acts as one", trig_pulse, 1'b1);
        do_arm();
        set_limit(1);

        // R3 edges on channel 9, with bit 5 of the edge byte set
        cur_req = "R3";
        lvl_mask = '0;
        edge_cfg = 8'h69;
        samp(32'h0); check("R3 rise first", trig_pulse, 1'b0);
        samp(32'h0); check("R3 rise steady low", trig_pulse, 1'b0);
        samp(32'h200); check("R3 rising fires", trig_pulse, 1'b1);
        do_arm();
        edge_cfg = 8'h89;
        samp(32'h200); samp(32'h200); check("R3 fall steady high", trig_pulse, 1'b0);
        samp(32'h0); check("R3 falling fires", trig_pulse, 1'b1);
        do_arm();
        edge_cfg = 8'hC9;
        samp(32'h0); check("R3 either first", trig_pulse, 1'b0);
        samp(32'h200); check("R3 either fires", trig_pulse, 1'b1);
        do_arm();

        // R5 edge straddling arm must not fire
        cur_req = "R5";
        edge_cfg = 8'h49;
        samp(32'h0);
        do_arm();
        samp(32'h200); check("R5 first after arm no edge", trig_pulse, 1'b0);
        samp(32'h0); samp(32'h200); check("R5 later rise fires", trig_pulse, 1'b1);
        do_arm();

        // R4 edge off
        cur_req = "R4";
        edge_cfg = 8'h09;
        set_pair(12, 2'b01);
        samp(32'h0000_1000); check("R4 edge off fires on level", trig_pulse, 1'b1);
        do_arm();

        // Random phase compared by the reference every cycle (R2-R9)
        cur_req = "R8 random";
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (n % 200 == 0) begin
                for (int c = 0; c < 32; c++) begin
                    int r;
                    r = $urandom % 12;
                    set_pair(c, (r == 10) ? 2'b01 : (r == 11) ? 2'b10 : (r < 2) ? 2'b11 : 2'b00);
                end
                edge_cfg = 8'($urandom);
            end
            smp_valid = ($urandom % 10) < 7;
            smp_data  = $urandom;
            arm       = ($urandom % 60) == 0;
            cnt_wr_lo = ($urandom % 150) == 0;
            cnt_wr_hi = ($urandom % 400) == 0;
            cnt_wdata = cnt_wr_hi ? 8'h00 : 8'($urandom % 5);
        end
        @(negedge clk);
        smp_valid = 0; arm = 0; cnt_wr_lo = 0; cnt_wr_hi = 0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule